// File: doc/BRIEF.md
# Nested Four-Level Interrupt Controller

This block chooses which of six interrupt requests is presented to a processor and keeps track of nested handler execution. Each source carries a request flag, an individual enable and a two-bit priority level. A global enable gates all grants. The winning request is presented as a registered vector address and level on a valid/ready pair. The processor's acknowledge is the ready side of that pair. A one-cycle return pulse ends the handler that is currently running, so the handler it interrupted resumes.

Preemption is strict. A new request is granted only when its level is above the highest level currently in service. When several eligible requests coexist, the highest level wins. A fixed source order settles ties at that level, and it has no other effect. A separate combinational output flags wake-up from power-down. Only three of the six sources may raise it.

Back-pressure rules: `vec_valid` rises only when a request has been registered. The address and level stay frozen while `vec_valid` is high and `vec_ready` is low. A transfer happens on a rising clock edge where both are high. After a transfer, and after any cycle with `iret` high, the controller skips one cycle before it arbitrates again, so the next decision sees the updated service state.

Top module: `nested_irq_ctrl`

## Requirements
- R1: A source is pending only when its flag, its enable bit and `glb_en` are all 1. With `glb_en` at 0, `vec_valid` never rises.
- R2: A source's level is `{prio_hi[i], prio_lo[i]}`. The value 0 is the lowest level and 3 is the highest.
- R3: Among eligible pending sources, the one with the highest level is granted. On a tie at that level, the lowest source index wins. The indices are 0 hard fault, 1 external 0, 2 brown-out, 3 watchdog, 4 timer 0, 5 serial-bus.
- R4: The vector address for each source index, from 0 to 5, is 0x0093, 0x0003, 0x0043, 0x0053, 0x000B and 0x0033.
- R5: While a handler is in service, a request is granted only if its level is strictly greater than `svc_level`. A request at an equal level is not granted even if it comes earlier in the source order, and neither is a request at a lower level.
- R6: A level-0 request is granted only when no handler is in service.
- R7: The grant is registered, so `vec_valid` rises on the first clock edge after the request is applied. While `vec_valid` is high and `vec_ready` is low, `vec_addr` and `vec_level` hold, even if the requests change. Arbitration resumes on the cycle after a transfer or a return.
- R8: A transfer marks `vec_level` as in service. `svc_level` reports the highest level in service. `iret` removes that highest level, so the interrupted level becomes current again. After the last return, `svc_active` is 0.
- R9: `wake` is 1 only when `pwr_down` is 1 and some source with index 1, 2 or 3 has both its flag and its enable set. `glb_en` has no effect on `wake`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_flag | input | 6 | Request flag per source |
| src_en | input | 6 | Individual enable per source |
| glb_en | input | 1 | Global enable for grants |
| prio_hi | input | 6 | Upper priority bit per source |
| prio_lo | input | 6 | Lower priority bit per source |
| vec_valid | output | 1 | A grant is being presented |
| vec_ready | input | 1 | Processor acknowledge |
| vec_addr | output | 16 | Vector address of the grant |
| vec_level | output | 2 | Level of the grant |
| iret | input | 1 | Return-from-handler pulse |
| svc_active | output | 1 | At least one level in service |
| svc_level | output | 2 | Highest level in service |
| pwr_down | input | 1 | Processor is powered down |
| wake | output | 1 | Wake-up request |

## Verification
The assertions check four properties on every cycle. The presented vector holds under back-pressure. A fresh grant never fails to exceed the level in service, and a level-0 grant never appears while a handler runs. Every grant traces back to a cycle with the global enable set, and the service mask takes the acknowledged level and empties on the last return. Some behaviour is visible only in the bench scenarios: which source wins among a given set of flags and levels, the exact address it gets, that the interrupted level is restored after a nested return, and the wake-up response over every combination of flags.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC   = 6;
  localparam int SRC_W  = $clog2(NSRC);
  localparam int LVL_W  = 2;
  localparam int NLVL   = 1 << LVL_W;
  localparam int ADDR_W = 16;

  // Sources allowed to end power-down: external 0, brown-out, watchdog.
  localparam logic [NSRC-1:0] WAKE_OK = 6'b001110;

  // Source index follows the tie-break order (index 0 wins ties).
  function automatic logic [ADDR_W-1:0] vec_of(input logic [SRC_W-1:0] idx);
    logic [ADDR_W-1:0] a;
    case (idx)
      3'd0:    a = 16'h0093;
      3'd1:    a = 16'h0003;
      3'd2:    a = 16'h0043;
      3'd3:    a = 16'h0053;
      3'd4:    a = 16'h000B;
      3'd5:    a = 16'h0033;
      default: a = 16'h0000;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int LW = LVL_W,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]         pend,
  input  logic [N-1:0][LW-1:0] lvl,
  input  logic                 ceil_valid,
  input  logic [LW-1:0]        ceil_lvl,
  output logic                 win_valid,
  output logic [IW-1:0]        win_idx,
  output logic [LW-1:0]        win_lvl
);
  // A source may compete only above the level already in service.
  logic [N-1:0] elig;
  for (genvar g = 0; g < N; g++) begin : g_elig
    assign elig[g] = pend[g] && (!ceil_valid || (lvl[g] > ceil_lvl));
  end

  // Scan from the last source down; ">=" lets lower indices take ties.
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i] && (!win_valid || (lvl[i] >= win_lvl))) begin
        win_valid = 1'b1;
        win_idx   = IW'(i);
        win_lvl   = lvl[i];
      end
    end
  end
endmodule

// File: rtl/irq_service_stack.sv
module irq_service_stack
  import irq_pkg::*;
#(
  parameter int LW = LVL_W,
  localparam int NL = 1 << LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [LW-1:0] push_lvl,
  input  logic          pop,
  output logic          active,
  output logic [LW-1:0] top_lvl
);
  logic [NL-1:0] mask;
  logic [NL-1:0] top_oh;
  logic [NL-1:0] push_oh;
  logic [NL-1:0] mask_nxt;

  assign active = |mask;

  always_comb begin
    top_lvl = '0;
    for (int k = 0; k < NL; k++) begin
      if (mask[k]) top_lvl = LW'(k);
    end
    top_oh = '0;
    if (active) top_oh[top_lvl] = 1'b1;
    push_oh = '0;
    push_oh[push_lvl] = 1'b1;
    mask_nxt = (mask & ~(pop ? top_oh : '0)) | (push ? push_oh : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mask <= '0;
    else        mask <= mask_nxt;
  end

  AST_PUSH_ABOVE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    push && active |-> push_lvl > top_lvl); // R5
  AST_PUSH_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> mask[$past(push_lvl)]); // R8
  AST_LAST_POP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push && ($countones(mask) == 1) |=> !active); // R8
endmodule

// File: rtl/irq_wake.sv
module irq_wake
  import irq_pkg::*;
#(
  parameter int N = NSRC,
  parameter logic [N-1:0] PERMIT = WAKE_OK
) (
  input  logic [N-1:0] flag,
  input  logic [N-1:0] en,
  input  logic         pwr_down,
  output logic         wake
);
  logic [N-1:0] qual;
  for (genvar g = 0; g < N; g++) begin : g_qual
    if (PERMIT[g]) begin : g_on
      assign qual[g] = flag[g] & en[g];
    end else begin : g_off
      assign qual[g] = 1'b0;
    end
  end
  assign wake = pwr_down & (|qual);
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req_flag,
  input  logic [NSRC-1:0]   src_en,
  input  logic              glb_en,
  input  logic [NSRC-1:0]   prio_hi,
  input  logic [NSRC-1:0]   prio_lo,
  output logic              vec_valid,
  input  logic              vec_ready,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [LVL_W-1:0]  vec_level,
  input  logic              iret,
  output logic              svc_active,
  output logic [LVL_W-1:0]  svc_level,
  input  logic              pwr_down,
  output logic              wake
);
  logic [NSRC-1:0]            pend;
  logic [NSRC-1:0][LVL_W-1:0] src_lvl;
  logic                       win_valid;
  logic [SRC_W-1:0]           win_idx;
  logic [LVL_W-1:0]           win_lvl;
  logic                       xfer;

  assign pend = req_flag & src_en & {NSRC{glb_en}};
  assign xfer = vec_valid & vec_ready;

  for (genvar g = 0; g < NSRC; g++) begin : g_lvl
    assign src_lvl[g] = {prio_hi[g], prio_lo[g]};
  end

  irq_arbiter #(.N(NSRC), .LW(LVL_W)) u_arb (
    .pend       (pend),
    .lvl        (src_lvl),
    .ceil_valid (svc_active),
    .ceil_lvl   (svc_level),
    .win_valid  (win_valid),
    .win_idx    (win_idx),
    .win_lvl    (win_lvl)
  );

  irq_service_stack #(.LW(LVL_W)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (xfer),
    .push_lvl (vec_level),
    .pop      (iret),
    .active   (svc_active),
    .top_lvl  (svc_level)
  );

  irq_wake #(.N(NSRC), .PERMIT(WAKE_OK)) u_wake (
    .flag     (req_flag),
    .en       (src_en),
    .pwr_down (pwr_down),
    .wake     (wake)
  );

  // Grant register: a new decision is taken only when nothing is
  // presented and the service mask is not changing this cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_addr  <= '0;
      vec_level <= '0;
    end else if (xfer) begin
      vec_valid <= 1'b0;
    end else if (!vec_valid && !iret && win_valid) begin
      vec_valid <= 1'b1;
      vec_addr  <= vec_of(win_idx);
      vec_level <= win_lvl;
    end
  end

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && !vec_ready |=> vec_valid && $stable(vec_addr) && $stable(vec_level)); // R7
  AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) && svc_active |-> vec_level > svc_level); // R5
  AST_LVL0_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) && (vec_level == '0) |-> !svc_active); // R6
  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> $past(glb_en)); // R1
endmodule

// File: tb/nested_irq_ctrl_test.sv
module nested_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  req_flag, src_en, prio_hi, prio_lo;
  logic        glb_en, vec_ready, iret, pwr_down;
  logic        vec_valid, svc_active, wake;
  logic [15:0] vec_addr;
  logic [1:0]  vec_level, svc_level;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  nested_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_flag(req_flag), .src_en(src_en),
    .glb_en(glb_en), .prio_hi(prio_hi), .prio_lo(prio_lo),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_addr(vec_addr),
    .vec_level(vec_level), .iret(iret), .svc_active(svc_active),
    .svc_level(svc_level), .pwr_down(pwr_down), .wake(wake)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_vec(input int s);
    case (s)
      0: return 16'h0093;
      1: return 16'h0003;
      2: return 16'h0043;
      3: return 16'h0053;
      4: return 16'h000B;
      default: return 16'h0033;
    endcase
  endfunction

  task automatic set_lvl(input int s, input int l);
    prio_hi[s] = l[1];
    prio_lo[s] = l[0];
  endtask

  task automatic ack_clear(input logic [5:0] clr);
    vec_ready = 1'b1;
    req_flag  = req_flag & ~clr;
    @(negedge clk);
    vec_ready = 1'b0;
  endtask

  task automatic ret();
    iret = 1'b1;
    @(negedge clk);
    iret = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_flag = '0; src_en = '0; glb_en = 1'b0;
    prio_hi = '0; prio_lo = '0; vec_ready = 1'b0; iret = 1'b0; pwr_down = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset vec_valid R7", 32'(vec_valid), 0);
    chk("reset svc_active R8", 32'(svc_active), 0);
    chk("reset wake R9", 32'(wake), 0);

    // R1 R2 R3 R4: arbitration sweep over all flag patterns, four level maps
    for (int p = 0; p < 4; p++) begin
      for (int pat = 0; pat < 64; pat++) begin
        logic [5:0] en_v, pend;
        logic g;
        int best, bl;
        en_v = (p % 2 == 0) ? 6'h3f : ~(6'b1 << (pat % 6));
        g = (pat % 7 != 3);
        for (int i = 0; i < 6; i++) set_lvl(i, (i * (p + 1) + p) % 4);
        src_en = en_v; glb_en = g; req_flag = 6'(pat);
        pend = 6'(pat) & en_v & {6{g}};
        best = -1; bl = -1;
        for (int i = 0; i < 6; i++) begin
          if (pend[i] && ((i * (p + 1) + p) % 4) > bl) begin
            best = i; bl = (i * (p + 1) + p) % 4;
          end
        end
        @(negedge clk); @(negedge clk);
        chk("R1 grant present", 32'(vec_valid), (best >= 0) ? 1 : 0);
        if (best >= 0 && vec_valid) begin
          chk("R3 R4 winner vector", 32'(vec_addr), 32'(exp_vec(best)));
          chk("R2 winner level", 32'(vec_level), 32'(bl));
          ack_clear(6'h3f);
          ret();
        end else begin
          req_flag = '0;
        end
        @(negedge clk);
        chk("R8 idle after sweep trial", 32'(svc_active), 0);
      end
    end

    // R5 R6 R8: preemption over every running/new level pair
    src_en = 6'h3f; glb_en = 1'b1;
    for (int L = 0; L < 4; L++) begin
      for (int M = 0; M < 4; M++) begin
        set_lvl(5, L);
        req_flag = 6'b100000;
        @(negedge clk); @(negedge clk);
        chk("R4 first handler vector", 32'(vec_addr), 32'h0033);
        ack_clear(6'b100000);
        chk("R8 level in service", 32'(svc_level), 32'(L));
        set_lvl(0, M);
        req_flag = 6'b000001;
        repeat (3) @(negedge clk);
        chk((M == 0) ? "R6 level0 blocked while busy" : "R5 strict preemption",
            32'(vec_valid), (M > L) ? 1 : 0);
        if (M > L) begin
          chk("R5 preempting vector", 32'(vec_addr), 32'h0093);
          ack_clear(6'b000001);
          chk("R8 nested level", 32'(svc_level), 32'(M));
          ret();
          chk("R8 resumed level", 32'(svc_level), 32'(L));
          chk("R8 still active", 32'(svc_active), 1);
          ret();
        end else begin
          req_flag = '0;
          ret();
        end
        @(negedge clk);
        chk("R8 idle after final return", 32'(svc_active), 0);
        chk("R8 nothing presented", 32'(vec_valid), 0);
      end
    end

    // R7: vector holds under stall, then re-arbitration after transfer
    set_lvl(4, 1); set_lvl(0, 3);
    req_flag = 6'b010000;
    chk("R7 not yet registered", 32'(vec_valid), 0);
    @(negedge clk);
    chk("R7 registered after one edge", 32'(vec_valid), 1);
    req_flag = 6'b010001;
    repeat (3) @(negedge clk);
    chk("R7 held address", 32'(vec_addr), 32'h000B);
    chk("R7 held level", 32'(vec_level), 1);
    ack_clear(6'b010000);
    chk("R7 dead cycle after transfer", 32'(vec_valid), 0);
    @(negedge clk);
    chk("R7 re-arbitrated vector", 32'(vec_addr), 32'h0093);
    chk("R7 re-arbitrated level", 32'(vec_level), 3);
    ack_clear(6'b000001);
    ret(); ret();
    @(negedge clk);
    chk("R8 idle after hold test", 32'(svc_active), 0);

    // R9: wake-up qualification, global enable off
    glb_en = 1'b0; pwr_down = 1'b1; src_en = 6'h3f;
    for (int pat = 0; pat < 64; pat++) begin
      req_flag = 6'(pat);
      #1;
      chk("R9 wake per flags", 32'(wake), ((pat & 6'b001110) != 0) ? 1 : 0);
    end
    src_en = 6'b110001; req_flag = 6'h3f; #1;
    chk("R9 disabled sources no wake", 32'(wake), 0);
    src_en = 6'h3f; pwr_down = 1'b0; #1;
    chk("R9 no wake when running", 32'(wake), 0);
    req_flag = '0;
    @(negedge clk);
    chk("R1 no grant with global off", 32'(vec_valid), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule